// File: doc/BRIEF.md
# Processor Status Flag Unit

This block holds the eight-bit status word of a small eight-bit processor and decides, flag by flag, which event may change it. Every flag has a short list of permitted writers:
- The ALU path supplies the result byte, the carry or borrow out of the top bit and of the low nibble, and a signed-overflow indication.
- Decoded instruction strobes set or clear individual flags, run a bit test against a memory byte, or signal a software break.
- Interrupt acceptance clears the interrupt enable.
- A whole-byte load restores the word after it has been pulled from the stack.

Besides the status byte, the unit drives a global interrupt-enable line. It also drives the page number used by direct addressing. That page comes from the page flag together with an external two-bit page-select value, and some select codes are reserved; a reserved code is reported on an error line.

Top module: `psw_unit`

## Requirements
- R1: The status word has carry in bit 0, zero in bit 1, interrupt enable in bit 2, half carry in bit 3, break in bit 4, page flag in bit 5, overflow in bit 6 and negative in bit 7. Reset clears the whole word to 00h. `intEnable` always equals bit 2.
- R2: A data update (`dataUpd`) does two things one cycle later: negative becomes result bit 7, and zero is set exactly when the result byte is 00h. It changes no other flag.
- R3: An arithmetic update (`arithUpd`) updates negative and zero as in R2. It also updates three more flags:
  - carry: with `aluSub`=0 it takes `aluCarryHi` (carry out of bit 7); with `aluSub`=1 it takes the inverse of `aluCarryHi` (borrow out of bit 7).
  - half carry: taken from `aluCarryMid` in the same way (carry out of bit 3 when adding, inverted borrow from bit 4 when subtracting).
  - overflow: takes `aluOverflow`.
- R4: Half carry changes only on an arithmetic update, on the clear-overflow strobe (which clears it), or on a whole-byte load.
- R5: The clear-overflow strobe clears overflow and half carry together. Overflow has no set strobe. When the clear-overflow strobe coincides with a bit test or an arithmetic update, the clear wins.
- R6: A bit test copies `memByte` bit 7 into negative and `memByte` bit 6 into overflow, and leaves zero and carry untouched. For negative, the bit test takes precedence over a data or arithmetic update in the same cycle.
- R7: The enable-interrupt strobe sets interrupt enable. The disable-interrupt strobe and interrupt acceptance each clear it. Either clear wins over a simultaneous enable.
- R8: The software-break strobe sets the break flag. Only a whole-byte load can clear it.
- R9: The set-page strobe sets the page flag and the clear-page strobe clears it. When both arrive in the same cycle, the clear wins.
- R10: With the page flag at 0, `dirPage` is 0 and `pageErr` is 0 whatever `pageSel` holds. With the page flag at 1, `pageSel`=00 gives page 0 and `pageSel`=01 gives page 1.
- R11: With the page flag at 1 and `pageSel` at 10 or 11, `pageErr` is 1 and `dirPage` is forced to 0.
- R12: A whole-byte load puts `loadByte` into the status word one cycle later and overrides every other update strobe in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aluResult | input | 8 | Result byte of the current operation |
| aluCarryHi | input | 1 | Carry (add) or borrow (subtract) out of bit 7 |
| aluCarryMid | input | 1 | Carry out of bit 3 (add) or borrow from bit 4 (subtract) |
| aluOverflow | input | 1 | Signed overflow of the operation |
| aluSub | input | 1 | 1 when the operation is a subtraction |
| dataUpd | input | 1 | Update negative and zero from the result |
| arithUpd | input | 1 | Update negative, zero, carry, half carry and overflow |
| bitTest | input | 1 | Bit-test instruction strobe |
| memByte | input | 8 | Memory operand for the bit test |
| eiStrobe | input | 1 | Enable-interrupt instruction |
| diStrobe | input | 1 | Disable-interrupt instruction |
| intAck | input | 1 | Interrupt accepted |
| setPage | input | 1 | Set-page instruction |
| clrPage | input | 1 | Clear-page instruction |
| clrOvf | input | 1 | Clear-overflow instruction |
| brkStrobe | input | 1 | Software break |
| loadEn | input | 1 | Whole-byte load strobe |
| loadByte | input | 8 | Byte to load |
| pageSel | input | 2 | Page-select register value |
| statusWord | output | 8 | Current status word |
| intEnable | output | 1 | Global interrupt enable |
| dirPage | output | 1 | Page for direct addressing |
| pageErr | output | 1 | Reserved page code selected |

## Verification
The assertions assume that every strobe and data input is a clean two-valued level, stable across each rising edge, and that `pageSel` only changes away from the edge. Overlaps between strobes are not excluded; the priority rules in R5 to R9 and R12 cover them. The bench drives all inputs on the falling edge. It sweeps every combination of the twelve strobe and mode bits together with varied data, sweeps add and subtract over a dense grid of operands, and sweeps every page-select code under both page-flag values. Because of this, no overlap is left to chance.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int PSW_W  = 8;
  localparam int BIT_C  = 0;
  localparam int BIT_Z  = 1;
  localparam int BIT_I  = 2;
  localparam int BIT_H  = 3;
  localparam int BIT_B  = 4;
  localparam int BIT_G  = 5;
  localparam int BIT_V  = 6;
  localparam int BIT_N  = 7;

  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_ALU  = 2'd1,
    SRC_MEM  = 2'd2,
    SRC_CLR  = 2'd3
  } flagSrc_e;

  typedef struct packed {
    logic     load;
    flagSrc_e nSrc;
    flagSrc_e vSrc;
    logic     zUpd;
    logic     cUpd;
    logic     hAlu;
    logic     hClr;
    logic     iSet;
    logic     iClr;
    logic     gSet;
    logic     gClr;
    logic     bSet;
  } flagCmd_t;
endpackage

// File: rtl/psw_ctrl.sv
module psw_ctrl
  import psw_pkg::*;
(
  input  logic     dataUpd,
  input  logic     arithUpd,
  input  logic     bitTest,
  input  logic     eiStrobe,
  input  logic     diStrobe,
  input  logic     intAck,
  input  logic     setPage,
  input  logic     clrPage,
  input  logic     clrOvf,
  input  logic     brkStrobe,
  input  logic     loadEn,
  output flagCmd_t cmd
);
  logic resultUpd;
  logic intOff;

  always_comb begin
    resultUpd = dataUpd | arithUpd;
    intOff    = diStrobe | intAck;

    cmd       = '0;
    cmd.load  = loadEn;

    // negative: bit test outranks result updates
    if (bitTest)        cmd.nSrc = SRC_MEM;
    else if (resultUpd) cmd.nSrc = SRC_ALU;
    else                cmd.nSrc = SRC_HOLD;

    // overflow: clear outranks bit test outranks arithmetic
    if (clrOvf)         cmd.vSrc = SRC_CLR;
    else if (bitTest)   cmd.vSrc = SRC_MEM;
    else if (arithUpd)  cmd.vSrc = SRC_ALU;
    else                cmd.vSrc = SRC_HOLD;

    cmd.zUpd = resultUpd;
    cmd.cUpd = arithUpd;
    cmd.hClr = clrOvf;
    cmd.hAlu = arithUpd & ~clrOvf;
    cmd.iClr = intOff;
    cmd.iSet = eiStrobe & ~intOff;
    cmd.gClr = clrPage;
    cmd.gSet = setPage & ~clrPage;
    cmd.bSet = brkStrobe;
  end
endmodule

// File: rtl/psw_dp.sv
module psw_dp
  import psw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  flagCmd_t         cmd,
  input  logic [PSW_W-1:0] aluResult,
  input  logic             aluCarryHi,
  input  logic             aluCarryMid,
  input  logic             aluOverflow,
  input  logic             aluSub,
  input  logic [PSW_W-1:0] memByte,
  input  logic [PSW_W-1:0] loadByte,
  output logic [PSW_W-1:0] psw
);
  logic [PSW_W-1:0] pswNext;
  logic             carryFlag;
  logic             halfFlag;
  logic             resultZero;

  always_comb begin
    carryFlag  = aluSub ? ~aluCarryHi  : aluCarryHi;
    halfFlag   = aluSub ? ~aluCarryMid : aluCarryMid;
    resultZero = (aluResult == '0);

    pswNext = psw;
    if (cmd.load) begin
      pswNext = loadByte;
    end else begin
      unique case (cmd.nSrc)
        SRC_ALU: pswNext[BIT_N] = aluResult[PSW_W-1];
        SRC_MEM: pswNext[BIT_N] = memByte[7];
        SRC_CLR: pswNext[BIT_N] = 1'b0;
        default: pswNext[BIT_N] = psw[BIT_N];
      endcase
      unique case (cmd.vSrc)
        SRC_ALU: pswNext[BIT_V] = aluOverflow;
        SRC_MEM: pswNext[BIT_V] = memByte[6];
        SRC_CLR: pswNext[BIT_V] = 1'b0;
        default: pswNext[BIT_V] = psw[BIT_V];
      endcase
      if (cmd.zUpd) pswNext[BIT_Z] = resultZero;
      if (cmd.cUpd) pswNext[BIT_C] = carryFlag;
      if (cmd.hClr)      pswNext[BIT_H] = 1'b0;
      else if (cmd.hAlu) pswNext[BIT_H] = halfFlag;
      if (cmd.iClr)      pswNext[BIT_I] = 1'b0;
      else if (cmd.iSet) pswNext[BIT_I] = 1'b1;
      if (cmd.gClr)      pswNext[BIT_G] = 1'b0;
      else if (cmd.gSet) pswNext[BIT_G] = 1'b1;
      if (cmd.bSet)      pswNext[BIT_B] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) psw <= '0;
    else       psw <= pswNext;
  end

  AST_HALF_WRITERS: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.hAlu && !cmd.hClr && !cmd.load) |=> $stable(psw[BIT_H])); // R4
  AST_NO_OVERFLOW_SET: assert property (@(posedge clk) disable iff (!rstN)
    ((cmd.vSrc == SRC_HOLD || cmd.vSrc == SRC_CLR) && !cmd.load) |=> (!psw[BIT_V] || $past(psw[BIT_V]))); // R5
  AST_INT_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.iClr && !cmd.load) |=> !psw[BIT_I]); // R7
  AST_BREAK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (psw[BIT_B] && !cmd.load) |=> psw[BIT_B]); // R8
endmodule

// File: rtl/psw_page.sv
module psw_page #(
  parameter  int NUM_PAGES  = 2,
  parameter  int PAGE_SEL_W = 2,
  localparam int PAGE_W     = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic                  gFlag,
  input  logic [PAGE_SEL_W-1:0] pageSel,
  output logic [PAGE_W-1:0]     dirPage,
  output logic                  pageErr
);
  logic selReserved;

  generate
    if ((1 << PAGE_SEL_W) > NUM_PAGES) begin : g_reserved
      assign selReserved = (int'(pageSel) >= NUM_PAGES);
    end else begin : g_full
      assign selReserved = 1'b0;
    end
  endgenerate

  always_comb begin
    pageErr = gFlag & selReserved;
    dirPage = '0;
    if (gFlag && !selReserved) dirPage = pageSel[PAGE_W-1:0];
  end
endmodule

// File: rtl/psw_unit.sv
module psw_unit
  import psw_pkg::*;
#(
  parameter  int NUM_PAGES  = 2,
  parameter  int PAGE_SEL_W = 2,
  localparam int PAGE_W     = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PSW_W-1:0]      aluResult,
  input  logic                  aluCarryHi,
  input  logic                  aluCarryMid,
  input  logic                  aluOverflow,
  input  logic                  aluSub,
  input  logic                  dataUpd,
  input  logic                  arithUpd,
  input  logic                  bitTest,
  input  logic [PSW_W-1:0]      memByte,
  input  logic                  eiStrobe,
  input  logic                  diStrobe,
  input  logic                  intAck,
  input  logic                  setPage,
  input  logic                  clrPage,
  input  logic                  clrOvf,
  input  logic                  brkStrobe,
  input  logic                  loadEn,
  input  logic [PSW_W-1:0]      loadByte,
  input  logic [PAGE_SEL_W-1:0] pageSel,
  output logic [PSW_W-1:0]      statusWord,
  output logic                  intEnable,
  output logic [PAGE_W-1:0]     dirPage,
  output logic                  pageErr
);
  flagCmd_t cmd;

  psw_ctrl u_ctrl (
    .dataUpd(dataUpd), .arithUpd(arithUpd), .bitTest(bitTest),
    .eiStrobe(eiStrobe), .diStrobe(diStrobe), .intAck(intAck),
    .setPage(setPage), .clrPage(clrPage), .clrOvf(clrOvf),
    .brkStrobe(brkStrobe), .loadEn(loadEn), .cmd(cmd)
  );

  psw_dp u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .aluResult(aluResult), .aluCarryHi(aluCarryHi), .aluCarryMid(aluCarryMid),
    .aluOverflow(aluOverflow), .aluSub(aluSub), .memByte(memByte),
    .loadByte(loadByte), .psw(statusWord)
  );

  psw_page #(.NUM_PAGES(NUM_PAGES), .PAGE_SEL_W(PAGE_SEL_W)) u_page (
    .gFlag(statusWord[BIT_G]), .pageSel(pageSel),
    .dirPage(dirPage), .pageErr(pageErr)
  );

  assign intEnable = statusWord[BIT_I];

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> (statusWord == $past(loadByte))); // R12
  AST_RESERVED_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    pageErr |-> (dirPage == '0 && statusWord[BIT_G])); // R11
  AST_FLAT_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    !statusWord[BIT_G] |-> (dirPage == '0 && !pageErr)); // R10
endmodule

// File: tb/psw_unit_bench.sv
module psw_unit_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] aluResult = '0;
  logic       aluCarryHi = 1'b0, aluCarryMid = 1'b0, aluOverflow = 1'b0, aluSub = 1'b0;
  logic       dataUpd = 1'b0, arithUpd = 1'b0, bitTest = 1'b0;
  logic [7:0] memByte = '0;
  logic       eiStrobe = 1'b0, diStrobe = 1'b0, intAck = 1'b0;
  logic       setPage = 1'b0, clrPage = 1'b0, clrOvf = 1'b0, brkStrobe = 1'b0;
  logic       loadEn = 1'b0;
  logic [7:0] loadByte = '0;
  logic [1:0] pageSel = '0;
  logic [7:0] statusWord;
  logic       intEnable;
  logic [0:0] dirPage;
  logic       pageErr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] model = '0;

  always #10 clk = ~clk;

  psw_unit u_psw_unit (
    .clk(clk), .rstN(rstN), .aluResult(aluResult), .aluCarryHi(aluCarryHi),
    .aluCarryMid(aluCarryMid), .aluOverflow(aluOverflow), .aluSub(aluSub),
    .dataUpd(dataUpd), .arithUpd(arithUpd), .bitTest(bitTest), .memByte(memByte),
    .eiStrobe(eiStrobe), .diStrobe(diStrobe), .intAck(intAck), .setPage(setPage),
    .clrPage(clrPage), .clrOvf(clrOvf), .brkStrobe(brkStrobe), .loadEn(loadEn),
    .loadByte(loadByte), .pageSel(pageSel), .statusWord(statusWord),
    .intEnable(intEnable), .dirPage(dirPage), .pageErr(pageErr)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic idle();
    dataUpd = 0; arithUpd = 0; bitTest = 0; eiStrobe = 0; diStrobe = 0; intAck = 0;
    setPage = 0; clrPage = 0; clrOvf = 0; brkStrobe = 0; loadEn = 0; aluSub = 0;
  endtask

  // Expected next word from the requirements (R2..R9, R12)
  function automatic logic [7:0] nextWord(logic [7:0] s);
    logic [7:0] n = s;
    if (loadEn) return loadByte;
    if (bitTest) n[7] = memByte[7];
    else if (dataUpd || arithUpd) n[7] = aluResult[7];
    if (clrOvf) n[6] = 1'b0;
    else if (bitTest) n[6] = memByte[6];
    else if (arithUpd) n[6] = aluOverflow;
    if (clrPage) n[5] = 1'b0; else if (setPage) n[5] = 1'b1;
    if (brkStrobe) n[4] = 1'b1;
    if (clrOvf) n[3] = 1'b0; else if (arithUpd) n[3] = aluSub ? ~aluCarryMid : aluCarryMid;
    if (diStrobe || intAck) n[2] = 1'b0; else if (eiStrobe) n[2] = 1'b1;
    if (dataUpd || arithUpd) n[1] = (aluResult == 8'h00);
    if (arithUpd) n[0] = aluSub ? ~aluCarryHi : aluCarryHi;
    return n;
  endfunction

  // Inputs already driven at a falling edge; one clock later compare.
  task automatic step(string tag);
    model = nextWord(model);
    @(negedge clk);
    check(tag, statusWord, model);
    check({tag, " intEnable R1"}, {7'd0, intEnable}, {7'd0, model[2]});
  endtask

  task automatic checkPage(string tag);
    logic [7:0] expPage;
    logic [7:0] expErr;
    expErr  = {7'd0, model[5] && pageSel[1]};
    expPage = {7'd0, model[5] && pageSel == 2'b01};
    check({tag, " dirPage"}, {7'd0, dirPage}, expPage);
    check({tag, " pageErr"}, {7'd0, pageErr}, expErr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset word", statusWord, 8'h00);
    check("R1 reset intEnable", {7'd0, intEnable}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    // R1 bit positions with literal values
    eiStrobe = 1; step("R1 ei"); check("R1 ei literal", statusWord, 8'h04); idle();
    setPage = 1; step("R9 setPage"); check("R1 G literal", statusWord, 8'h24); idle();
    brkStrobe = 1; step("R8 brk"); check("R1 B literal", statusWord, 8'h34); idle();
    clrPage = 1; setPage = 1; step("R9 clr wins"); check("R9 literal", statusWord, 8'h14); idle();
    intAck = 1; eiStrobe = 1; step("R7 ack beats ei"); check("R7 literal", statusWord, 8'h10); idle();
    memByte = 8'hC0; bitTest = 1; step("R6 bit test"); check("R1 NV literal", statusWord, 8'hD0); idle();
    clrOvf = 1; step("R5 clrOvf"); check("R5 literal", statusWord, 8'h90); idle();

    // R2 data updates over every result byte
    for (int r = 0; r < 256; r++) begin
      aluResult = 8'(r); aluCarryHi = r[0]; aluOverflow = r[1]; aluCarryMid = r[2];
      dataUpd = 1; step("R2 data");
      check("R2 N", {7'd0, statusWord[7]}, {7'd0, r[7]});
      check("R2 Z", {7'd0, statusWord[1]}, {7'd0, r == 0});
    end
    idle();

    // R3 add and subtract, expectations computed arithmetically
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b += 5) begin
          logic [8:0] full;
          logic [7:0] res;
          logic expC, expH, expV;
          if (s == 0) begin
            full = 9'(a) + 9'(b);
            res = full[7:0];
            aluCarryHi = full[8];
            aluCarryMid = ((a & 15) + (b & 15)) > 15;
            expC = full[8];
            expH = aluCarryMid;
            expV = (a[7] == b[7]) && (res[7] != a[7]);
          end else begin
            res = 8'(a - b);
            aluCarryHi = a < b;
            aluCarryMid = (a & 15) < (b & 15);
            expC = a >= b;
            expH = (a & 15) >= (b & 15);
            expV = (a[7] != b[7]) && (res[7] != a[7]);
          end
          aluSub = s[0]; aluResult = res; aluOverflow = expV; arithUpd = 1;
          step("R3 arith");
          check("R3 C", {7'd0, statusWord[0]}, {7'd0, expC});
          check("R3 H", {7'd0, statusWord[3]}, {7'd0, expH});
          check("R3 V", {7'd0, statusWord[6]}, {7'd0, expV});
          check("R3 Z", {7'd0, statusWord[1]}, {7'd0, res == 0});
        end
      end
    end
    idle();

    // R6 bit test over every memory byte, with a conflicting result update
    for (int m = 0; m < 256; m++) begin
      memByte = 8'(m); bitTest = 1; dataUpd = m[0]; aluResult = 8'(~m);
      step("R6 bit test");
      check("R6 N", {7'd0, statusWord[7]}, {7'd0, m[7]});
    end
    idle();

    // R12 load of every byte, with all other strobes active
    for (int v = 0; v < 256; v++) begin
      loadByte = 8'(v); loadEn = 1; clrOvf = 1; brkStrobe = 1; eiStrobe = 1; arithUpd = 1;
      step("R12 load");
      check("R12 literal", statusWord, 8'(v));
    end
    idle();

    // R4 R5 R7 R8 R9 R10 R11: every strobe combination with varied data
    for (int k = 0; k < 16384; k++) begin
      logic [13:0] kk = 14'(k);
      {loadEn, dataUpd, arithUpd, bitTest, eiStrobe, diStrobe, intAck,
       setPage, clrPage, clrOvf, brkStrobe, aluSub} = kk[11:0];
      pageSel = kk[13:12];
      aluResult = 8'(k * 37); aluCarryHi = k[3]; aluCarryMid = k[6]; aluOverflow = k[9];
      memByte = 8'(k * 91); loadByte = 8'(k * 53 + 7);
      step("R4 R5 R7 R8 R9 combo");
      checkPage("R10 R11 combo");
    end
    idle();

    // R10 R11 explicit page sweep
    for (int g = 0; g < 2; g++) begin
      if (g == 0) clrPage = 1; else setPage = 1;
      step("R9 page flag");
      idle();
      for (int p = 0; p < 4; p++) begin
        pageSel = 2'(p);
        #1;
        checkPage(g == 0 ? "R10 flat" : (p > 1 ? "R11 reserved" : "R10 paged"));
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule